// File: doc/BRIEF.md
# Selectable Periodic Interrupt Generator

This block produces a periodic interrupt for a real-time clock. A binary prescaler counts ticks of the slow timekeeping clock (nominally 32.768 kHz), which arrive as a one-cycle enable in the system clock domain. A three-bit rate code held in a control byte picks one of six prescaler taps. Each rising edge of the chosen tap yields a one-cycle pulse and sets a sticky event flag. The interrupt line is high while that flag is set and the rate code is a valid one.

Software programs the control byte with a single write. The rate code lands in bits 6:4. Bit 7 is the event flag. Writing 0 there clears the flag, and writing 1 leaves it as it is, so a read-modify-write cannot destroy an event that is still pending. A prescaler clear input, shared with the time counter's reset control, zeroes the prescaler. The phase of the periodic pulses then starts again from that point.

Top module: `rtc_periodic_irq`

## Requirements
- R1: After reset the control byte reads 0x00, and `irq` and `per_pulse` are low.
- R2: With one tick per cycle, rate codes 1 to 6 give a pulse every 128, 512, 2048, 8192, 16384 and 32768 ticks (256, 64, 16, 4, 2 and 1 Hz). In general code c uses prescaler bit PRESC_W-9+2(c-1) for c up to 4, bit PRESC_W-2 for code 5 and bit PRESC_W-1 for code 6.
- R3: `per_pulse` is high for exactly one cycle per rising edge of the selected tap. After a prescaler clear, the first pulse comes when the counter reaches half the interval. The pulse and the flag become visible one cycle after the counter update that makes the tap rise.
- R4: A pulse sets the event flag (bit 7 of the control byte), and the flag stays set until software clears it.
- R5: A write with bit 7 = 0 clears the flag. A write with bit 7 = 1 neither sets nor clears it.
- R6: Every write loads bits 6:4 into the rate code. A read returns {flag, rate code, 4'b0000}.
- R7: Codes 0 and 7 disable the generator: no pulse and no flag. Code 7 still reads back as 7.
- R8: `irq` is high exactly when the flag is set and the stored code is 1 to 6. It follows the flag and the code in the same cycle as the control byte changes.
- R9: When a flag-clearing write and a new pulse land on the same clock edge, the flag ends up set.
- R10: `tick_en` low freezes the prescaler, so no pulses occur. `presc_clr` zeroes the prescaler, takes priority over a tick, and never causes a pulse by itself.
- R11: Changing the rate code never produces a pulse unless the newly selected tap actually rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle enable per timekeeping-clock tick |
| presc_clr | input | 1 | Zero the prescaler (phase restart) |
| cfg_wr | input | 1 | Write strobe for the control byte |
| cfg_wdata | input | 8 | Write data: bit 7 flag (0 clears), bits 6:4 rate code |
| ctl_rdata | output | 8 | Control byte: {flag, rate code, 4'b0000} |
| per_pulse | output | 1 | One-cycle pulse per period |
| irq | output | 1 | Periodic interrupt request |

## Verification
The flag's set path (a new period) and its clear path (a software write with bit 7 low) can fall on the same clock edge. The bench lines them up by clearing the prescaler and then counting edges, so the write strobe lands on exactly the edge where the first tap rise reaches the flag. It then expects the flag to stay set. The next edge carries a lone clear, and the bench expects that one to take effect, which shows the priority is real and not a dropped write.

// File: rtl/rtc_periodic_pkg.sv
package rtc_periodic_pkg;

    localparam int NUM_RATES = 6;
    localparam int CODE_W    = 3;

    typedef logic [CODE_W-1:0] rate_code_t;

    // Rate codes 1..NUM_RATES are live; 0 and 7 are disabled.
    function automatic logic code_is_live(input rate_code_t code);
        return (code != '0) && (int'(code) <= NUM_RATES);
    endfunction

    // Prescaler bit used for a given live code.
    function automatic int tap_bit(input int presc_w, input int code);
        int pos;
        if (code <= 4)
            pos = presc_w - 9 + 2 * (code - 1);
        else if (code == 5)
            pos = presc_w - 2;
        else
            pos = presc_w - 1;
        return pos;
    endfunction

endpackage

// File: rtl/rtc_per_prescaler.sv
module rtc_per_prescaler #(
    parameter int PRESC_W = 15
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_en,
    input  logic               clr,
    output logic [PRESC_W-1:0] cnt
);

    typedef struct packed {
        logic [PRESC_W-1:0] cnt;
    } presc_state_t;

    presc_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr)
            st_d.cnt = '0;
        else if (tick_en)
            st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign cnt = st_q.cnt;

endmodule

// File: rtl/rtc_per_tap_edge.sv
module rtc_per_tap_edge
    import rtc_periodic_pkg::*;
#(
    parameter int PRESC_W = 15
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PRESC_W-1:0] cnt,
    input  rate_code_t         code,
    output logic               edge_hit
);

    typedef struct packed {
        logic [NUM_RATES-1:0] taps_prev;
    } edge_state_t;

    edge_state_t st_d, st_q;
    logic [NUM_RATES-1:0] taps;
    logic [NUM_RATES-1:0] rises;
    rate_code_t           idx;

    for (genvar g = 0; g < NUM_RATES; g++) begin : g_tap
        localparam int POS = tap_bit(PRESC_W, g + 1);
        assign taps[g] = cnt[POS];
    end

    always_comb begin
        st_d           = st_q;
        st_d.taps_prev = taps;
        rises          = taps & ~st_q.taps_prev;
        idx            = code - 1'b1;
        edge_hit       = 1'b0;
        if (code_is_live(code))
            edge_hit = rises[idx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

endmodule

// File: rtl/rtc_per_ctrl.sv
module rtc_per_ctrl
    import rtc_periodic_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [7:0] wdata,
    input  logic       edge_hit,
    output rate_code_t code,
    output logic [7:0] rdata,
    output logic       pulse,
    output logic       irq
);

    typedef struct packed {
        logic       flag;
        rate_code_t code;
        logic       pulse;
        logic       irq;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;
    logic        unused_low_bits;

    assign unused_low_bits = ^wdata[3:0];

    always_comb begin
        st_d       = st_q;
        st_d.pulse = edge_hit;
        if (wr) begin
            st_d.code = wdata[6:4];
            if (!wdata[7])
                st_d.flag = 1'b0;
        end
        if (edge_hit)
            st_d.flag = 1'b1;
        st_d.irq = st_d.flag && code_is_live(st_d.code);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign code  = st_q.code;
    assign rdata = {st_q.flag, st_q.code, 4'b0000};
    assign pulse = st_q.pulse;
    assign irq   = st_q.irq;

endmodule

// File: rtl/rtc_periodic_irq.sv
module rtc_periodic_irq
    import rtc_periodic_pkg::*;
#(
    parameter int PRESC_W = 15
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic       presc_clr,
    input  logic       cfg_wr,
    input  logic [7:0] cfg_wdata,
    output logic [7:0] ctl_rdata,
    output logic       per_pulse,
    output logic       irq
);

    logic [PRESC_W-1:0] cnt;
    rate_code_t         code;
    logic               edge_hit;

    rtc_per_prescaler #(.PRESC_W(PRESC_W)) i_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .clr     (presc_clr),
        .cnt     (cnt)
    );

    rtc_per_tap_edge #(.PRESC_W(PRESC_W)) i_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt      (cnt),
        .code     (code),
        .edge_hit (edge_hit)
    );

    rtc_per_ctrl i_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (cfg_wr),
        .wdata    (cfg_wdata),
        .edge_hit (edge_hit),
        .code     (code),
        .rdata    (ctl_rdata),
        .pulse    (per_pulse),
        .irq      (irq)
    );

endmodule

// File: rtl/rtc_periodic_irq_chk.sv
module rtc_periodic_irq_chk
    import rtc_periodic_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       tick_en,
    input logic       cfg_wr,
    input logic [7:0] cfg_wdata,
    input logic [7:0] ctl_rdata,
    input logic       per_pulse,
    input logic       irq
);

    AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        per_pulse |=> !per_pulse); // R3

    AST_PULSE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        per_pulse |-> ctl_rdata[7]); // R4

    AST_FLAG_FALL_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctl_rdata[7]) |-> ($past(cfg_wr) && !$past(cfg_wdata[7]))); // R5

    AST_CLEAR_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cfg_wr) && !$past(cfg_wdata[7]) && !per_pulse) |-> !irq); // R8

    AST_IRQ_NEEDS_LIVE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ctl_rdata[7] && code_is_live(ctl_rdata[6:4]))); // R8

    AST_DISABLED_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        per_pulse |-> code_is_live($past(ctl_rdata[6:4]))); // R7

    AST_FROZEN_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        per_pulse |-> $past(tick_en, 2)); // R10

endmodule

bind rtc_periodic_irq rtc_periodic_irq_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .cfg_wr    (cfg_wr),
    .cfg_wdata (cfg_wdata),
    .ctl_rdata (ctl_rdata),
    .per_pulse (per_pulse),
    .irq       (irq)
);

// File: tb/test_rtc_periodic_irq.sv
module test_rtc_periodic_irq;

    localparam int CLK_PERIOD = 10;
    localparam int PW         = 11;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       presc_clr = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic [7:0] ctl_rdata;
    logic       per_pulse;
    logic       irq;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_periodic_irq #(.PRESC_W(PW)) i_rtc_periodic_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .presc_clr (presc_clr),
        .cfg_wr    (cfg_wr),
        .cfg_wdata (cfg_wdata),
        .ctl_rdata (ctl_rdata),
        .per_pulse (per_pulse),
        .irq       (irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [7:0] v);
        @(negedge clk);
        cfg_wr    = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_wr    = 1'b0;
    endtask

    // Clear at edge E0 with ticking enabled; returns at the negedge after E0.
    task automatic clear_presc();
        @(negedge clk);
        presc_clr = 1'b1;
        tick_en   = 1'b1;
        @(negedge clk);
        presc_clr = 1'b0;
    endtask

    function automatic int tap_of(input int code);
        if (code <= 4) return PW - 9 + 2 * (code - 1);
        if (code == 5) return PW - 2;
        return PW - 1;
    endfunction

    task automatic sweep_code(input int code);
        int  live, half, per, n_cyc, mism, seen, want;
        logic exp_p;
        live = (code >= 1 && code <= 6) ? 1 : 0;
        half = live ? (1 << tap_of(code)) : 0;
        per  = 2 * half;
        n_cyc = live ? (2 * per + half + 2) : ((1 << PW) + 8);
        tick_en = 1'b0;
        write_reg({1'b0, code[2:0], 4'b0000});
        clear_presc();
        mism = 0; seen = 0; want = 0;
        for (int n = 1; n <= n_cyc; n++) begin
            @(posedge clk);
            #1;
            exp_p = live && (((n - 1) % per) == half);
            if (per_pulse !== exp_p) mism++;
            if (per_pulse) seen++;
            if (exp_p) want++;
        end
        @(negedge clk);
        tick_en = 1'b0;
        chk($sformatf("R2 R3 pulse timing code %0d", code), mism, 0);
        chk($sformatf("R2 R7 pulse count code %0d", code), seen, want);
        repeat (2) @(negedge clk);
        chk($sformatf("R4 R7 flag code %0d", code), ctl_rdata[7], live);
        chk($sformatf("R8 irq code %0d", code), irq, live);
        chk($sformatf("R6 readback code %0d", code), ctl_rdata[6:0], code << 4);
        write_reg({1'b1, code[2:0], 4'b0000});
        chk($sformatf("R5 write one keeps flag code %0d", code), ctl_rdata[7], live);
        chk($sformatf("R8 irq after write one code %0d", code), irq, live);
        write_reg({1'b0, code[2:0], 4'b0000});
        chk($sformatf("R5 write zero clears code %0d", code), ctl_rdata[7], 0);
        chk($sformatf("R8 irq after clear code %0d", code), irq, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int bad;
        repeat (3) @(negedge clk);
        chk("R1 reset control byte", ctl_rdata, 0);
        chk("R1 reset irq", irq, 0);
        chk("R1 reset pulse", per_pulse, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release control byte", ctl_rdata, 0);

        for (int c = 0; c < 8; c++) sweep_code(c);

        // R9: clearing write on the same edge as the first pulse.
        tick_en = 1'b0;
        write_reg(8'h10);
        clear_presc();
        repeat (4) @(posedge clk);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_wdata = 8'h10;
        @(posedge clk); #1;
        chk("R9 pulse on collision edge", per_pulse, 1);
        chk("R9 set wins over clear", ctl_rdata[7], 1);
        chk("R9 irq on collision edge", irq, 1);
        @(posedge clk); #1;
        chk("R9 lone clear next edge", ctl_rdata[7], 0);
        @(negedge clk);
        cfg_wr = 1'b0;

        // R10, R11: frozen prescaler with tap differences, then code change.
        tick_en = 1'b0;
        write_reg(8'h20);
        clear_presc();
        repeat (64) @(posedge clk);
        @(negedge clk);
        tick_en = 1'b0;
        repeat (2) @(negedge clk);
        write_reg(8'h20);
        chk("R5 flag cleared before code change", ctl_rdata[7], 0);
        write_reg(8'h30);
        bad = 0;
        for (int n = 0; n < 40; n++) begin
            @(posedge clk); #1;
            if (per_pulse) bad++;
        end
        chk("R10 R11 no pulse on code change while frozen", bad, 0);
        chk("R11 flag untouched by code change", ctl_rdata[7], 0);
        chk("R6 code readback after change", ctl_rdata[6:4], 3);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule